// File: doc/BRIEF.md
# Synthesizer Divider Programming and Dividers

This block holds the divider settings of a frequency synthesizer and contains the two digital dividers those settings control. Both dividers run on the VCO clock.

The feedback divider counts the VCO clock down by a 9-bit loop modulus. It sends one single-cycle pulse per period to the phase detector. With a 16 MHz reference divided by 16, the loop settles with the VCO at the modulus value in MHz.

The output divider passes the VCO clock straight through, or divides it by 2, 4 or 8, under a 2-bit select. Each output step is therefore 1 MHz divided by the output ratio.

The settings enter through a parallel holding latch:
- While the load control is low, the latch is transparent and the inputs act on the dividers at once.
- A rising edge of the load control freezes the values, and they stay held while the control remains high.

A flag reports whenever the held loop modulus lies outside the range in which the loop can lock.

Top module: `synth_div_core`

## Requirements
- R1: While `load` is low the holding latch is transparent: a change on `m_in` or `n_in` reaches the range flag and the dividers without waiting for a clock edge.
- R2: A rising edge on `load` captures `m_in` and `n_in`. Later input changes have no effect on `m_bad` or on the feedback period while `load` stays high.
- R3: The select encodes the output ratio as 2'b00 = VCO clock passed through, 2'b01 = divide by 2, 2'b10 = divide by 4 and 2'b11 = divide by 8. The divided outputs have a 50% duty cycle.
- R4: `m_in` is an unsigned binary modulus, bit 8 weighing 256 and bit 0 weighing 1. `fb_pulse` is high for exactly one VCO cycle in every M cycles.
- R5: `m_bad` is high exactly when the held modulus is below 200 or above 400. The values 200 and 400 are valid.
- R6: The feedback counter takes a new modulus only at its reload. The count in progress completes with the old value, and the following period uses the new one.
- R7: A new output select takes effect only when the 3-bit divide counter passes through zero, that is, on the clock edge that takes it from 7 to 0.
- R8: A synchronous active-high `rst` clears both counters and leaves the holding latch unchanged. The divide counter reads 0 during reset and counts 1, 2, ... from the first clock edge with `rst` low. The first `fb_pulse` is seen after the M-th such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst | input | 1 | Synchronous active-high reset of both counters |
| load | input | 1 | Parallel load control; the latch is transparent while low |
| m_in | input | 9 | Loop divider modulus |
| n_in | input | 2 | Output divider select |
| fb_pulse | output | 1 | Feedback pulse to the phase detector |
| clk_out | output | 1 | Divided output clock |
| m_bad | output | 1 | Held modulus outside 200..400 |

## Verification
The assertions check properties that hold on every cycle:
- the divide counter steps by one on each edge;
- the feedback counter either decrements or reloads the held modulus, and never truncates a count;
- the output select changes only while the divide counter is at zero;
- the range flag is steady while the latch is closed;
- both counters are zero after reset.

The bench scenarios cover what needs a known stimulus history:
- the feedback period measured for a range of moduli, including 1 and the range limits;
- the flag at 199, 200, 400 and 401;
- latch transparency against holding;
- the waveform of each output ratio;
- the exact edge at which a new select or a new modulus takes effect;
- a reset that leaves the held settings in place.

// File: rtl/synth_div_core.sv
module synth_div_core #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int M_LO  = 200,
  parameter int M_HI  = 400
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [N_W-1:0] n_in,
  output logic           fb_pulse,
  output logic           clk_out,
  output logic           m_bad
);
  localparam int CNT_W = (1 << N_W) - 1;

  logic [M_W-1:0]   m_hold;
  logic [N_W-1:0]   n_hold;
  logic [M_W-1:0]   fb_cnt;
  logic [CNT_W-1:0] cnt;
  logic [N_W-1:0]   sel;

  always_latch begin
    if (!load) begin
      m_hold <= m_in;
      n_hold <= n_in;
    end
  end

  assign m_bad = (m_hold < M_W'(M_LO)) || (m_hold > M_W'(M_HI));

  assign fb_pulse = (fb_cnt == M_W'(1));

  always_ff @(posedge clk) begin
    if (rst)
      fb_cnt <= '0;
    else if (fb_cnt <= M_W'(1))
      fb_cnt <= m_hold;
    else
      fb_cnt <= fb_cnt - M_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sel <= n_hold;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (&cnt)
        sel <= n_hold;
    end
  end

  logic [(1<<N_W)-1:0] taps;
  assign taps = {cnt, clk};
  assign clk_out = taps[sel];
endmodule

module synth_div_chk #(
  parameter int M_W   = 9,
  parameter int N_W   = 2,
  parameter int CNT_W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic           fb_pulse,
  input logic           m_bad,
  input logic [M_W-1:0] m_hold,
  input logic [M_W-1:0] fb_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [N_W-1:0] sel
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + CNT_W'(1)); // R3

  AST_FB_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fb_cnt) > M_W'(1)) |-> fb_cnt == $past(fb_cnt) - M_W'(1)); // R6

  AST_FB_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fb_cnt) <= M_W'(1)) |-> fb_cnt == $past(m_hold)); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && m_hold > M_W'(1)) |=> !fb_pulse); // R4

  AST_SEL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel) |-> cnt == '0); // R7

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (load && $past(load)) |-> $stable(m_bad)); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (cnt == '0 && fb_cnt == '0)); // R8
endmodule

bind synth_div_core synth_div_chk #(.M_W(M_W), .N_W(N_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .fb_pulse(fb_pulse), .m_bad(m_bad),
  .m_hold(m_hold), .fb_cnt(fb_cnt), .cnt(cnt), .sel(sel)
);

// File: tb/tb_synth_div_core.sv
`timescale 1ns/1ps
module tb_synth_div_core;
  logic       clk = 0;
  logic       rst = 1;
  logic       load = 0;
  logic [8:0] m_in = 9'd300;
  logic [1:0] n_in = 2'b01;
  logic       fb_pulse, clk_out, m_bad;

  int tests = 0;
  int fails = 0;
  int k = 0;
  bit done = 0;

  synth_div_core dut (
    .clk(clk), .rst(rst), .load(load), .m_in(m_in), .n_in(n_in),
    .fb_pulse(fb_pulse), .clk_out(clk_out), .m_bad(m_bad)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else k <= k + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, k);
    end
  endtask

  task automatic do_reset(input int m, input int n);
    load = 0; m_in = 9'(m); n_in = 2'(n); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic next_pulse(output int kk);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!fb_pulse && guard < 2000);
    kk = k;
  endtask

  task automatic t_period(input int m);
    int p0, p1, p2, highs;
    do_reset(m, 0);
    next_pulse(p0);
    chk(p0 == m, "R8 first pulse edge", p0, m);
    highs = 1;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      if (fb_pulse) highs++;
    end
    chk(highs == 2, "R4 pulses per M+1 cycles", highs, 2);
    next_pulse(p1);
    next_pulse(p2);
    chk(p2 - p1 == m, "R4 period", p2 - p1, m);
  endtask

  task automatic t_flag();
    int vals[8] = '{199, 200, 400, 401, 0, 511, 262, 300};
    load = 0;
    foreach (vals[i]) begin
      m_in = 9'(vals[i]);
      #1;
      chk(m_bad == (vals[i] < 200 || vals[i] > 400), "R5 range flag", m_bad,
          int'(vals[i] < 200 || vals[i] > 400));
    end
  endtask

  task automatic t_latch();
    int p0, p1, p2;
    do_reset(250, 0);
    @(negedge clk);
    m_in = 9'd100; #1;
    chk(m_bad == 1, "R1 transparent flag", m_bad, 1);
    m_in = 9'd20; #1;
    load = 1; #1;
    m_in = 9'd450; #1;
    chk(m_bad == 1, "R2 held low value", m_bad, 1);
    m_in = 9'd300; #1;
    chk(m_bad == 1, "R2 held ignores in-range", m_bad, 1);
    next_pulse(p0);
    next_pulse(p1);
    next_pulse(p2);
    chk(p2 - p1 == 20, "R2 held period", p2 - p1, 20);
    load = 0; #1;
    chk(m_bad == 0, "R1 reopen flag", m_bad, 0);
  endtask

  task automatic t_reset_keeps();
    int p0;
    load = 0; m_in = 9'd300; n_in = 2'b01;
    @(negedge clk);
    load = 1;
    m_in = 9'd100;
    rst = 1;
    repeat (2) @(negedge clk);
    chk(clk_out == 0, "R8 counter cleared in reset", clk_out, 0);
    chk(m_bad == 0, "R8 latch kept", m_bad, 0);
    rst = 0;
    @(negedge clk);
    chk(clk_out == 1, "R8 first count", clk_out, 1);
    next_pulse(p0);
    chk(p0 == 300, "R8 held M after reset", p0, 300);
    load = 0;
  endtask

  task automatic t_div(input int n);
    int exp;
    do_reset(300, n);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      exp = (n == 0) ? 0 : (((k % 8) >> (n - 1)) & 1);
      chk(clk_out == exp, $sformatf("R3 ratio sel %0d low phase", n), clk_out, exp);
      if (n == 0) begin
        @(posedge clk); #1;
        chk(clk_out == 1, "R3 pass-through high phase", clk_out, 1);
      end
    end
  endtask

  task automatic t_sel_switch();
    int exp;
    bit sw = 0;
    do_reset(300, 1);
    do @(negedge clk); while (k % 8 != 3);
    n_in = 2'b11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (k % 8 == 0) sw = 1;
      exp = sw ? (((k % 8) >> 2) & 1) : (k & 1);
      chk(clk_out == exp, "R7 select switch at zero", clk_out, exp);
    end
  endtask

  task automatic t_reload();
    int p0, p1, p2;
    do_reset(210, 0);
    next_pulse(p0);
    @(negedge clk);
    m_in = 9'd230;
    next_pulse(p1);
    chk(p1 - p0 == 210, "R6 old count completes", p1 - p0, 210);
    next_pulse(p2);
    chk(p2 - p1 == 230, "R6 new count used", p2 - p1, 230);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_flag();
    t_period(5);
    t_period(1);
    t_period(200);
    t_period(400);
    t_latch();
    t_reset_keeps();
    for (int n = 0; n < 4; n++) t_div(n);
    t_sel_switch();
    t_reload();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule